// File: doc/BRIEF.md
# Byte-Wide External Read Sequencer

This block is the read side of an external memory controller. The processor always asks for 16-bit words, but the external data path is only eight bits wide. Each word is fetched as two consecutive byte cycles: the low byte comes first, from the even address, and the high byte follows from the odd address. A code fetch may ask for a burst of one to eight words. Chip select, output enable and the low byte enable are held active across the whole burst. The high byte enable is never used on this narrow path.

A request gives a start address, a burst length, a wait count that stretches every byte cycle, and a flag that marks a single-byte access. On a single-byte access the bus still carries the full word sequence. The flag only changes the value returned: the wanted byte is zero-extended and the other byte is dropped. Each assembled word is presented with a one-clock valid pulse. A one-clock done pulse marks the end of the transfer. A request that arrives while a transfer is running is ignored.

Top module: `xbus_rd_seq`

## Requirements
- R1: After reset, cs_n_o, oe_n_o, lbe_n_o and hbe_n_o are 1, bus_addr_o is 0, and word_vld_o and done_o are 0.
- R2: Each word is read as two byte cycles, low byte first. bus_addr_o rises by one at the start of every byte cycle of a burst, so word k of a burst starting at even address B uses B+2k and then B+2k+1.
- R3: hbe_n_o is 1 in every cycle.
- R4: The first byte address of a transfer is start_addr_i with bit 0 cleared.
- R5: cs_n_o, oe_n_o and lbe_n_o go to 0 on the clock edge that accepts a request. They stay 0 through every byte cycle and return to 1 on the edge that samples the last byte.
- R6: Every byte cycle lasts wait_i+1 clocks, using the wait_i value latched with the request. bus_data_i is sampled on the clock edge that ends the byte cycle.
- R7: A burst_len_i value of n gives n+1 words, which is 2(n+1) byte cycles.
- R8: In the clock after each high byte is sampled, rd_word_o holds {high byte, low byte} and word_vld_o is 1 for exactly that clock. done_o is 1 only in the clock that carries the last word.
- R9: When byte_mode_i is 1, rd_word_o is {8'h00, byte}. The byte is the high byte if start_addr_i bit 0 was 1 and the low byte otherwise. The bus sequence is the same as for a word read.
- R10: A request raised while a transfer is in progress is ignored. It does not change the address sequence or the returned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a transfer (accepted only when idle) |
| start_addr_i | input | ADDR_W | Byte address of the first word (bit 0 selects the byte in byte mode) |
| byte_mode_i | input | 1 | 1 = return one zero-extended byte per word |
| burst_len_i | input | LEN_W | Number of words minus one |
| wait_i | input | WAIT_W | Extra clocks per byte cycle |
| bus_addr_o | output | ADDR_W | External byte address |
| cs_n_o | output | 1 | Chip select, active low |
| oe_n_o | output | 1 | Output enable, active low |
| lbe_n_o | output | 1 | Low byte enable, active low |
| hbe_n_o | output | 1 | High byte enable, always inactive (1) |
| bus_data_i | input | DATA_W | External read data |
| rd_word_o | output | WORD_W | Assembled word |
| word_vld_o | output | 1 | One-clock pulse per returned word |
| done_o | output | 1 | One-clock pulse with the last word |

## Verification
The assertions assume that req_i, start_addr_i, byte_mode_i, burst_len_i and wait_i are stable around the accepting clock edge. They also assume that bus_data_i settles before the edge that ends each byte cycle. The bench drives every input on the falling clock edge. Its memory model computes bus_data_i combinationally from bus_addr_o, so both conditions are met. The bench covers every wait count, every burst length, both byte-mode settings and both address parities. Every transfer also receives a stray request one clock into its second byte cycle, which covers the ignored-request case.

// File: rtl/xbus_rd_pkg.sv
package xbus_rd_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_READ = 1'b1
   } rd_state_e;

   // bytes in a burst of (len+1) words, minus one, for a counter of width W
   function automatic int last_byte_index(input int len, input int lanes);
      return (len + 1) * lanes - 1;
   endfunction

endpackage

// File: rtl/xbus_wait_timer.sv
module xbus_wait_timer #(
   parameter int WAIT_W = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic              run_i,
   input  logic [WAIT_W-1:0] wait_i,
   output logic              end_o
);

   logic [WAIT_W-1:0] cnt_q;
   logic [WAIT_W-1:0] lim_q;

   generate
      if (WAIT_W < 1) begin : g_bad_wait
         $error("WAIT_W must be at least 1");
      end
   endgenerate

   assign end_o = run_i && (cnt_q == lim_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         lim_q <= '0;
      end else if (load_i) begin
         cnt_q <= '0;
         lim_q <= wait_i;
      end else if (run_i) begin
         cnt_q <= end_o ? '0 : cnt_q + 1'b1;
      end
   end

   a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i |-> (cnt_q <= lim_q));

endmodule

// File: rtl/xbus_addr_gen.sv
module xbus_addr_gen #(
   parameter int ADDR_W = 20,
   parameter int LEN_W  = 3,
   parameter int LANES  = 2,
   parameter int CNT_W  = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic              step_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic [LEN_W-1:0]  len_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              last_o
);
   import xbus_rd_pkg::*;

   localparam int LIDX_W = $clog2(LANES);

   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  left_q;

   assign addr_o = addr_q;
   assign last_o = (left_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         addr_q <= '0;
         left_q <= '0;
      end else if (load_i) begin
         addr_q <= {start_addr_i[ADDR_W-1:LIDX_W], {LIDX_W{1'b0}}};
         left_q <= CNT_W'(last_byte_index(int'(len_i), LANES));
      end else if (step_i && !last_o) begin
         addr_q <= addr_q + 1'b1;
         left_q <= left_q - 1'b1;
      end
   end

   // R2: consecutive byte cycles use consecutive addresses
   a_r2_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !last_o && !load_i) |=> (addr_o == $past(addr_o) + 1'b1));

endmodule

// File: rtl/xbus_word_asm.sv
module xbus_word_asm #(
   parameter int DATA_W = 8,
   parameter int WORD_W = 16
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          load_i,
   input  logic                          byte_mode_i,
   input  logic [$clog2(WORD_W/DATA_W)-1:0] sel_i,
   input  logic                          cap_i,
   input  logic [$clog2(WORD_W/DATA_W)-1:0] lane_i,
   input  logic [DATA_W-1:0]             data_i,
   output logic [WORD_W-1:0]             word_o,
   output logic                          vld_o
);

   localparam int LANES  = WORD_W / DATA_W;
   localparam int LIDX_W = $clog2(LANES);

   logic [DATA_W-1:0] lane_q [LANES-1];
   logic [WORD_W-1:0] full;
   logic [DATA_W-1:0] picked;
   logic              byte_mode_q;
   logic [LIDX_W-1:0] sel_q;

   generate
      for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                                lane_q[g] <= '0;
            else if (cap_i && lane_i == LIDX_W'(g))     lane_q[g] <= data_i;
         end
      end
   endgenerate

   always_comb begin
      full = '0;
      for (int i = 0; i < LANES - 1; i++) full[i*DATA_W +: DATA_W] = lane_q[i];
      full[WORD_W-1 -: DATA_W] = data_i;
      picked = full[int'(sel_q)*DATA_W +: DATA_W];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         byte_mode_q <= 1'b0;
         sel_q       <= '0;
         word_o      <= '0;
         vld_o       <= 1'b0;
      end else begin
         vld_o <= 1'b0;
         if (load_i) begin
            byte_mode_q <= byte_mode_i;
            sel_q       <= sel_i;
         end
         if (cap_i && lane_i == LIDX_W'(LANES - 1)) begin
            word_o <= byte_mode_q ? WORD_W'(picked) : full;
            vld_o  <= 1'b1;
         end
      end
   end

   // R8: word valid is a single-clock pulse
   a_r8_vld_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o |=> !vld_o);

endmodule

// File: rtl/xbus_rd_seq.sv
module xbus_rd_seq #(
   parameter int ADDR_W    = 20,
   parameter int DATA_W    = 8,
   parameter int WORD_W    = 16,
   parameter int MAX_BURST = 8,
   parameter int WAIT_W    = 3,
   localparam int LEN_W    = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic              byte_mode_i,
   input  logic [LEN_W-1:0]  burst_len_i,
   input  logic [WAIT_W-1:0] wait_i,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic              cs_n_o,
   output logic              oe_n_o,
   output logic              lbe_n_o,
   output logic              hbe_n_o,
   input  logic [DATA_W-1:0] bus_data_i,
   output logic [WORD_W-1:0] rd_word_o,
   output logic              word_vld_o,
   output logic              done_o
);
   import xbus_rd_pkg::*;

   localparam int LANES  = WORD_W / DATA_W;
   localparam int LIDX_W = $clog2(LANES);
   localparam int CNT_W  = $clog2(MAX_BURST * LANES);

   generate
      if (WORD_W % DATA_W != 0 || LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_ratio
         $error("WORD_W must be a power-of-two multiple (>=2) of DATA_W");
      end
      if (MAX_BURST < 2 || (MAX_BURST & (MAX_BURST - 1)) != 0) begin : g_bad_burst
         $error("MAX_BURST must be a power of two, at least 2");
      end
      if (ADDR_W <= LIDX_W) begin : g_bad_addr
         $error("ADDR_W too small");
      end
   endgenerate

   rd_state_e state_q;
   logic      accept, running, step, last_byte, finish;
   logic      strb_q, done_q;

   assign accept  = (state_q == ST_IDLE) && req_i;
   assign running = (state_q == ST_READ);
   assign finish  = step && last_byte;

   xbus_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (accept),
      .run_i  (running),
      .wait_i (wait_i),
      .end_o  (step)
   );

   xbus_addr_gen #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W),
      .LANES  (LANES),
      .CNT_W  (CNT_W)
   ) u_addr (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .load_i       (accept),
      .step_i       (step),
      .start_addr_i (start_addr_i),
      .len_i        (burst_len_i),
      .addr_o       (bus_addr_o),
      .last_o       (last_byte)
   );

   xbus_word_asm #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_asm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (accept),
      .byte_mode_i (byte_mode_i),
      .sel_i       (start_addr_i[LIDX_W-1:0]),
      .cap_i       (step),
      .lane_i      (bus_addr_o[LIDX_W-1:0]),
      .data_i      (bus_data_i),
      .word_o      (rd_word_o),
      .vld_o       (word_vld_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         strb_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= finish;
         if (accept) begin
            state_q <= ST_READ;
            strb_q  <= 1'b1;
         end else if (finish) begin
            state_q <= ST_IDLE;
            strb_q  <= 1'b0;
         end
      end
   end

   assign cs_n_o  = ~strb_q;
   assign oe_n_o  = ~strb_q;
   assign lbe_n_o = ~strb_q;
   assign hbe_n_o = 1'b1;
   assign done_o  = done_q;

   // R4: a transfer always begins on an even byte
   a_r4_even_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cs_n_o) |-> (bus_addr_o[0] == 1'b0));

   // R6: address is held for the whole byte cycle
   a_r6_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cs_n_o && !step) |=> $stable(bus_addr_o));

   // R5: strobes stay active until the last byte is sampled, then drop
   a_r5_strobe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cs_n_o && !finish) |=> !cs_n_o);
   a_r5_strobe_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      finish |=> (cs_n_o && oe_n_o && lbe_n_o));

   // R8: done accompanies the final word
   a_r8_done_with_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> word_vld_o);

   // R10: a busy-time request does not restart the address sequence
   a_r10_busy_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cs_n_o && req_i && !step) |=> $stable(bus_addr_o));

endmodule

// File: tb/xbus_rd_seq_tb_top.sv
module xbus_rd_seq_tb_top;

   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic [AW-1:0] sa = '0;
   logic          bm = 1'b0;
   logic [2:0]    blen = '0;
   logic [2:0]    wt = '0;
   logic [AW-1:0] baddr;
   logic          cs_n, oe_n, lbe_n, hbe_n;
   logic [7:0]    bdata;
   logic [15:0]   word;
   logic          vld, done;

   int vectors = 0;
   int fails   = 0;

   always #5 clk = ~clk;

   function automatic logic [7:0] mem(input logic [AW-1:0] a);
      return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5B;
   endfunction

   assign bdata = mem(baddr);

   xbus_rd_seq #(.ADDR_W(AW), .DATA_W(8), .WORD_W(16), .MAX_BURST(8), .WAIT_W(3)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .start_addr_i(sa),
      .byte_mode_i(bm), .burst_len_i(blen), .wait_i(wt),
      .bus_addr_o(baddr), .cs_n_o(cs_n), .oe_n_o(oe_n), .lbe_n_o(lbe_n),
      .hbe_n_o(hbe_n), .bus_data_i(bdata), .rd_word_o(word),
      .word_vld_o(vld), .done_o(done)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] exp_word(input logic [AW-1:0] s, input int k, input logic m);
      logic [AW-1:0] b;
      logic [7:0] lo, hi;
      b  = {s[AW-1:1], 1'b0} + AW'(2*k);
      lo = mem(b);
      hi = mem(b + 1'b1);
      if (m) return {8'h00, s[0] ? hi : lo};
      return {hi, lo};
   endfunction

   task automatic xfer(input logic [AW-1:0] s, input int n, input int w, input logic m);
      logic [AW-1:0] base;
      base = {s[AW-1:1], 1'b0};
      @(negedge clk);
      req = 1'b1; sa = s; blen = 3'(n); wt = 3'(w); bm = m;
      for (int j = 0; j < 2*(n+1); j++) begin
         for (int c = 0; c <= w; c++) begin
            @(negedge clk);
            req = 1'b0;
            chk("R2 R4 address", 32'(baddr), 32'(base + AW'(j)));
            chk("R5 strobes active", {29'd0, cs_n, oe_n, lbe_n}, 32'd0);
            chk("R3 high enable", 32'(hbe_n), 32'd1);
            chk("R6 R8 valid timing", 32'(vld), 32'(j > 0 && j % 2 == 0 && c == 0));
            chk("R8 done", 32'(done), 32'd0);
            if (j > 0 && j % 2 == 0 && c == 0)
               chk(m ? "R9 byte word" : "R8 word", 32'(word), 32'(exp_word(s, j/2 - 1, m)));
            if (j == 1 && c == 0) begin
               // R10: stray request mid-burst with different parameters
               req = 1'b1; sa = s ^ 16'h3C01; blen = 3'd0; wt = 3'(~w); bm = ~m;
            end
         end
      end
      @(negedge clk);
      req = 1'b0;
      chk("R5 strobes released", {29'd0, cs_n, oe_n, lbe_n}, 32'd7);
      chk("R7 R8 final valid", 32'(vld), 32'd1);
      chk("R8 final done", 32'(done), 32'd1);
      chk(m ? "R9 last byte word" : "R8 last word", 32'(word), 32'(exp_word(s, n, m)));
      @(negedge clk);
      chk("R8 pulse ends", {30'd0, vld, done}, 32'd0);
      chk("R10 idle after burst", 32'(cs_n), 32'd1);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      chk("R1 reset strobes", {28'd0, cs_n, oe_n, lbe_n, hbe_n}, 32'hF);
      chk("R1 reset address", 32'(baddr), 32'd0);
      chk("R1 reset pulses", {30'd0, vld, done}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", {28'd0, cs_n, oe_n, lbe_n, hbe_n}, 32'hF);
      chk("R1 idle address", 32'(baddr), 32'd0);
      for (int w = 0; w < 8; w++)
         for (int n = 0; n < 8; n++)
            for (int m = 0; m < 2; m++)
               for (int odd = 0; odd < 2; odd++)
                  xfer(AW'(16'h00F8 + 16'h0123 * (w * 8 + n)) | AW'(odd) & ~AW'(odd ? 0 : 1) | AW'(odd),
                       n, w, m[0]);
      // address carry across a 256-byte boundary, odd start
      xfer(16'h01FB, 7, 1, 1'b0);
      xfer(16'hFFF9, 3, 0, 1'b1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule